// File: doc/BRIEF.md
# UART interrupt identification and priority

This block gathers the receive and transmit conditions of a 16550-style serial port into one interrupt request and a four-bit identification code. It keeps sticky copies of the receive line errors, checks the receive FIFO fill against a selectable threshold, latches character-timeout and transmitter-empty events, and picks the most urgent enabled condition. Each condition goes away on the bus access that services it. A line-status read clears the errors. A receive-buffer read or any FIFO push clears the timeout. A drop of the fill level below the threshold clears the data-available condition. A transmit write, or an identification read while the transmitter-empty condition is the one shown, clears that condition.

The serial shifters, the FIFO storage, the timeout timer and the baud generator sit outside this block. They feed it single-cycle event pulses and the current FIFO count. The bus decoder feeds it one-cycle access strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: With no enabled condition pending, `iir` reads 4'b0001: bit 0 is 1 and bits 3:1 are 0. `irq` is high exactly in the cycles where `iir[0]` is 0.
- R2: The code on `iir` is 4'b0110 for a line error, 4'b0100 for receive data available, 4'b1100 for character timeout and 4'b0010 for transmitter empty.
- R3: Each error pulse sets a sticky bit in `lsr_err`: bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break. The bit is visible from the next cycle. A `rd_lsr` strobe clears all four bits. A pulse that arrives in the same cycle as the read still leaves its bit set.
- R4: Priority runs from line error (highest) to data available, then character timeout, then transmitter empty (lowest). Data available is shown ahead of timeout when both are pending.
- R5: Data available is pending in the same cycle that `rx_count` is at or above the threshold chosen by `trig_sel`. The thresholds are 0→1, 1→4, 2→8 and 3→14 characters. The condition drops as soon as the count falls below the threshold.
- R6: A `rx_timeout` pulse latches the character-timeout condition only while `rx_count` is nonzero. A pulse with an empty FIFO is ignored. A `rd_rbr` or `rx_push` strobe clears the condition and wins over a timeout pulse in the same cycle.
- R7: A rising edge of `thr_empty` latches the transmitter-empty condition. `wr_thr` clears it. `rd_iir` clears it only while `iir` shows 4'b0010, and leaves it pending when another code is shown.
- R8: `en_line` masks the line-error condition, `en_rx` masks both data-available and timeout, and `en_tx` masks transmitter-empty. A masked condition is neither reported nor requested, but its latched state survives and appears once it is enabled.
- R9: After reset, `lsr_err` is 0, no condition is latched, `iir` is 4'b0001 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_pulse | input | 4 | Error events {break, framing, parity, overrun} |
| rx_count | input | CNT_W | Current receive FIFO fill |
| trig_sel | input | 2 | Threshold select |
| rx_timeout | input | 1 | Timeout timer expiry pulse |
| rx_push | input | 1 | Receive FIFO write pulse |
| thr_empty | input | 1 | Transmit holding register empty level |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line-status read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| wr_thr | input | 1 | Transmit holding write strobe |
| en_line | input | 1 | Line error enable |
| en_rx | input | 1 | Receive data / timeout enable |
| en_tx | input | 1 | Transmitter empty enable |
| irq | output | 1 | Interrupt request |
| iir | output | 4 | Identification code |
| lsr_err | output | 4 | Sticky error bits (line-status bits 4:1) |

## Verification
The assertions assume that the strobes and event inputs are single-cycle pulses synchronous to `clk`. They also assume that `rx_count` never exceeds the FIFO depth. They do not assume that accesses are exclusive: a read, a write and a new event may share one cycle. The stimulus drives counts only within 0 to the depth. It runs directed sequences first, then a randomized phase that overlaps errors, timeouts, reads and pushes, so that the clear-against-set cases the requirements name come up often.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef enum logic [3:0] {
      IID_NONE = 4'b0001,
      IID_LINE = 4'b0110,
      IID_RXAV = 4'b0100,
      IID_TOUT = 4'b1100,
      IID_TXEM = 4'b0010
   } iid_e;

   localparam int NUM_SRC = 4;
   localparam int ERR_W   = 4;
   localparam int MAX_TRIG = 14;

   function automatic int trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return MAX_TRIG;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_linestat.sv
module uart_irq_linestat #(
   parameter int ERR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_W-1:0] err_pulse,
   input  logic             rd_lsr,
   output logic [ERR_W-1:0] err_q,
   output logic             line_pend
);

   for (genvar i = 0; i < ERR_W; i++) begin : g_err
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_q[i] <= 1'b0;
         else        err_q[i] <= (err_q[i] & ~rd_lsr) | err_pulse[i];
      end
   end

   assign line_pend = |err_q;

   a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lsr && err_pulse == '0) |=> (err_q == '0));

   a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lsr |=> ((err_q & $past(err_q)) == $past(err_q)));

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
   import uart_irq_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [1:0]       trig_sel,
   input  logic             rx_timeout,
   input  logic             rx_activity,
   input  logic             thr_empty,
   input  logic             wr_thr,
   input  logic             txem_ack,
   output logic             rxav_pend,
   output logic             tout_pend,
   output logic             txem_pend
);

   logic [CNT_W-1:0] thresh;
   logic             thr_empty_q;
   logic             txem_set;

   always_comb thresh = CNT_W'(trig_level(trig_sel));
   assign rxav_pend = (rx_count >= thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tout_pend <= 1'b0;
      else        tout_pend <= (tout_pend | (rx_timeout & (rx_count != '0))) & ~rx_activity;
   end

   assign txem_set = thr_empty & ~thr_empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_empty_q <= 1'b1;
         txem_pend   <= 1'b0;
      end else begin
         thr_empty_q <= thr_empty;
         txem_pend   <= (txem_pend | txem_set) & ~(wr_thr | txem_ack);
      end
   end

   a_r6_activity_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_activity |=> !tout_pend);

   a_r6_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!tout_pend && rx_count == '0) |=> !tout_pend);

   a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_thr |=> !txem_pend);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int N = NUM_SRC
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output iid_e         iid
);

   for (genvar i = 0; i < N; i++) begin : g_grant
      if (i == 0) begin : g_top
         assign grant[i] = req[i];
      end else begin : g_rest
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
   end

   always_comb begin
      iid = IID_NONE;
      if      (grant[0]) iid = IID_LINE;
      else if (grant[1]) iid = IID_RXAV;
      else if (grant[2]) iid = IID_TOUT;
      else if (grant[3]) iid = IID_TXEM;
   end

   always_comb begin
      a_r4_single_grant: assert ($onehot0(grant));
   end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       err_pulse,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [1:0]       trig_sel,
   input  logic             rx_timeout,
   input  logic             rx_push,
   input  logic             thr_empty,
   input  logic             rd_iir,
   input  logic             rd_lsr,
   input  logic             rd_rbr,
   input  logic             wr_thr,
   input  logic             en_line,
   input  logic             en_rx,
   input  logic             en_tx,
   output logic             irq,
   output logic [3:0]       iir,
   output logic [3:0]       lsr_err
);

   if (FIFO_DEPTH < MAX_TRIG) begin : g_depth_chk
      $error("uart_irq_ident: FIFO_DEPTH below highest trigger level");
   end

   logic               line_pend, rxav_pend, tout_pend, txem_pend;
   logic [NUM_SRC-1:0] req, grant;
   iid_e               iid;

   uart_irq_linestat #(.ERR_W(ERR_W)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_pulse (err_pulse),
      .rd_lsr    (rd_lsr),
      .err_q     (lsr_err),
      .line_pend (line_pend)
   );

   uart_irq_sources #(.CNT_W(CNT_W)) u_src (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_count    (rx_count),
      .trig_sel    (trig_sel),
      .rx_timeout  (rx_timeout),
      .rx_activity (rd_rbr | rx_push),
      .thr_empty   (thr_empty),
      .wr_thr      (wr_thr),
      .txem_ack    (rd_iir & grant[3]),
      .rxav_pend   (rxav_pend),
      .tout_pend   (tout_pend),
      .txem_pend   (txem_pend)
   );

   assign req = {txem_pend & en_tx, tout_pend & en_rx, rxav_pend & en_rx, line_pend & en_line};

   uart_irq_prio #(.N(NUM_SRC)) u_prio (
      .req   (req),
      .grant (grant),
      .iid   (iid)
   );

   assign iir = iid;
   assign irq = |grant;

   a_r1_irq_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !iir[0]);

   a_r4_line_first: assert property (@(posedge clk) disable iff (!rst_n)
      (en_line && lsr_err != 4'b0) |-> (iir == 4'b0110));

   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_line && !en_rx && !en_tx) |-> (!irq && iir == 4'b0001));

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

   localparam int DEPTH = 16;
   localparam int CW = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    err_pulse = '0;
   logic [CW-1:0] rx_count = '0;
   logic [1:0]    trig_sel = '0;
   logic          rx_timeout = 0, rx_push = 0, thr_empty = 1;
   logic          rd_iir = 0, rd_lsr = 0, rd_rbr = 0, wr_thr = 0;
   logic          en_line = 1, en_rx = 1, en_tx = 1;
   logic          irq;
   logic [3:0]    iir, lsr_err;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   bit [3:0] m_err;
   bit       m_tout, m_txem, m_thrq;

   always #4 clk = ~clk;

   uart_irq_ident #(.FIFO_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .rx_count(rx_count),
      .trig_sel(trig_sel), .rx_timeout(rx_timeout), .rx_push(rx_push),
      .thr_empty(thr_empty), .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
      .wr_thr(wr_thr), .en_line(en_line), .en_rx(en_rx), .en_tx(en_tx),
      .irq(irq), .iir(iir), .lsr_err(lsr_err));

   function automatic int level(input logic [1:0] s);
      int t[4] = '{1, 4, 8, 14};
      return t[s];
   endfunction

   function automatic logic [3:0] exp_id();
      if (en_line && m_err != 0)                return 4'b0110;
      if (en_rx && int'(rx_count) >= level(trig_sel)) return 4'b0100;
      if (en_rx && m_tout)                      return 4'b1100;
      if (en_tx && m_txem)                      return 4'b0010;
      return 4'b0001;
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // one cycle: compare outputs, clock, update model, clear pulses
   task automatic cyc(string tag);
      logic [3:0] id;
      #1;
      id = exp_id();
      check(tag, "iir", iir, id);
      check(tag, "irq", irq, !id[0]);
      check(tag, "lsr_err", lsr_err, m_err);
      @(posedge clk);
      m_err  = (m_err & ~{4{rd_lsr}}) | err_pulse;
      m_tout = (m_tout || (rx_timeout && rx_count != 0)) && !(rd_rbr || rx_push);
      m_txem = (m_txem || (thr_empty && !m_thrq)) && !(wr_thr || (rd_iir && id == 4'b0010));
      m_thrq = thr_empty;
      @(negedge clk);
      err_pulse = '0; rx_timeout = 0; rx_push = 0;
      rd_iir = 0; rd_lsr = 0; rd_rbr = 0; wr_thr = 0;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      m_err = 0; m_tout = 0; m_txem = 0; m_thrq = 1;
      repeat (3) @(negedge clk);
      // R9: reset state while reset is held
      cyc("R9");
      rst_n = 1;
      cyc("R9");

      // R3 / R2: each error alone, sticky, cleared by line-status read
      for (int i = 0; i < 4; i++) begin
         err_pulse = 4'b1 << i; cyc("R3");
         cyc("R2");
         rd_lsr = 1; cyc("R3");
         cyc("R1");
      end
      // R3: error in same cycle as read survives
      err_pulse = 4'b0001; cyc("R3");
      rd_lsr = 1; err_pulse = 4'b1000; cyc("R3");
      cyc("R3");
      rd_lsr = 1; cyc("R3");

      // R5: each threshold, at, below and above
      for (int s = 0; s < 4; s++) begin
         trig_sel = s[1:0];
         rx_count = CW'(level(s[1:0]) - 1); cyc("R5");
         rx_count = CW'(level(s[1:0]));     cyc("R5");
         rx_count = CW'(DEPTH);             cyc("R5");
         rx_count = CW'(level(s[1:0]) - 1); cyc("R5");
      end
      rx_count = 0; trig_sel = 2'd3;

      // R6: timeout ignored on empty, latched on nonempty, cleared by rbr / push
      rx_timeout = 1; cyc("R6");
      cyc("R6");
      rx_count = 3; rx_timeout = 1; cyc("R6");
      cyc("R6");
      rd_rbr = 1; cyc("R6");
      rx_timeout = 1; cyc("R6");
      rx_push = 1; rx_timeout = 1; cyc("R6");
      rx_timeout = 1; cyc("R6");
      // R4: data available reported ahead of timeout, error ahead of both
      trig_sel = 2'd1; rx_count = 5; cyc("R4");
      err_pulse = 4'b0100; cyc("R4");
      cyc("R4");
      rd_lsr = 1; cyc("R4");
      rx_count = 3; cyc("R4");
      rd_rbr = 1; rx_count = 2; cyc("R6");

      // R7: rising edge, IIR read while reported, write clears
      thr_empty = 0; cyc("R7");
      thr_empty = 1; cyc("R7");
      cyc("R7");
      rd_iir = 1; cyc("R7");
      cyc("R7");
      thr_empty = 0; cyc("R7");
      thr_empty = 1; cyc("R7");
      err_pulse = 4'b0010; cyc("R7");
      rd_iir = 1; cyc("R7");           // line error shown: transmitter-empty kept
      rd_lsr = 1; cyc("R7");
      cyc("R7");
      wr_thr = 1; cyc("R7");
      cyc("R7");

      // R8: masks hide but keep state
      thr_empty = 0; cyc("R8");
      thr_empty = 1; en_tx = 0; cyc("R8");
      err_pulse = 4'b0001; en_line = 0; cyc("R8");
      rx_count = 1; rx_timeout = 1; en_rx = 0; cyc("R8");
      rd_iir = 1; cyc("R8");
      en_tx = 1; cyc("R8");
      en_rx = 1; cyc("R8");
      en_line = 1; cyc("R8");
      rd_lsr = 1; rd_rbr = 1; cyc("R8");
      wr_thr = 1; cyc("R8");

      // randomized overlap of all events
      for (int k = 0; k < 600; k++) begin
         err_pulse  = ($urandom % 6 == 0) ? 4'($urandom) : 4'b0;
         rx_count   = CW'($urandom % (DEPTH + 1));
         if ($urandom % 8 == 0) trig_sel = 2'($urandom);
         rx_timeout = ($urandom % 4 == 0);
         rx_push    = ($urandom % 6 == 0);
         thr_empty  = ($urandom % 3 != 0);
         rd_iir     = ($urandom % 3 == 0);
         rd_lsr     = ($urandom % 5 == 0);
         rd_rbr     = ($urandom % 6 == 0);
         wr_thr     = ($urandom % 7 == 0);
         en_line    = ($urandom % 5 != 0);
         en_rx      = ($urandom % 5 != 0);
         en_tx      = ($urandom % 5 != 0);
         cyc("R4");
      end
      finish_run();
   end

endmodule